// File: doc/BRIEF.md
# Serial Pattern-Unlock Access Controller

This block sits on an asynchronous memory strobe bus, in front of an external memory and a hidden 64-bit register. Each bus cycle is seen as the active-low chip-enable input going low and then returning high; the cycle's type (read or write) and its data bit are taken from the strobes and the data-in line as they stood just before chip-enable rose. All strobes are sampled in the `clk_i` domain.

Normally the block is locked and simply forwards chip-enable to the memory. A read cycle arms a key comparator at bit 0. The following write cycles must then present the 64-bit key, LSB first, one bit per cycle on `d_i`. When all 64 bits match, a 64-cycle data window opens. During the window the memory's chip-enable is held inactive. Each write stores one bit of the hidden register and each read returns one bit on `q_o`, LSB first. When the window closes, the block is locked again.

Top module: `serial_unlock_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the block is locked with the compare pointer at 0, and `ce_no` equals `ce_ni`.
- R2: While locked (not in the data window), `ce_no` follows `ce_ni` in every clock cycle, for reads, writes and partial key sequences alike.
- R3: A read cycle has `ce_ni`=0, `oe_ni`=0 and `we_ni`=1, and it completes when `ce_ni` rises. When no window is open, a read cycle arms the comparator, or re-arms it, at key bit 0, discarding any partial match.
- R4: A write cycle has `ce_ni`=0 and `we_ni`=0. Once armed, write cycle k (k=0..63) compares `d_i` with bit k of the `KEY` parameter. A match on bit 63 opens the data window.
- R5: A mismatching key bit disarms the comparator. Later writes are ignored until a new read cycle arms it again.
- R6: Write cycles that arrive without a preceding arming read never open the window.
- R7: For the whole data window, `ce_no` stays 1 regardless of `ce_ni`.
- R8: Data-window write number k (k=0..63) stores `d_i` into bit k of the hidden register. Bits that are not written keep their value.
- R9: During data-window read number k, `q_oe_o` is 1 and `q_o` carries register bit k while `ce_ni` is low. At all other times `q_oe_o` is 0 and `q_o` is 0.
- R10: After the 64th data-window cycle, the block returns to the locked, unarmed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Host chip-enable, active low |
| oe_ni | input | 1 | Host output-enable, active low |
| we_ni | input | 1 | Host write-enable, active low |
| d_i | input | 1 | Serial data-in bit |
| ce_no | output | 1 | Memory chip-enable, active low |
| q_o | output | 1 | Serial data-out bit |
| q_oe_o | output | 1 | Drive enable for `q_o` (low means tri-stated) |

## Verification
The key sequence is tried in several forms: complete and correct; correct but with no arming read; broken by one wrong bit, with later bits trying to continue; and interrupted by a second read partway through. These forms separate a true unlock from pass-through, and abort from restart. Data windows are run with all-write, all-read and interleaved read/write traffic. A later read-back then shows bit order, and shows that the window closes after exactly 64 cycles.

// File: rtl/sul_pkg.sv
package sul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MATCH = 2'd1,
    ST_WIN   = 2'd2
  } sul_state_e;
endpackage

// File: rtl/sul_cycle_det.sv
module sul_cycle_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic we_ni,
  input  logic d_i,
  output logic rd_evt_o,
  output logic wr_evt_o,
  output logic bit_o
);
  logic ce_q, oe_q, we_q, d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q <= 1'b1;
      oe_q <= 1'b1;
      we_q <= 1'b1;
      d_q  <= 1'b0;
    end else begin
      ce_q <= ce_ni;
      oe_q <= oe_ni;
      we_q <= we_ni;
      d_q  <= d_i;
    end
  end

  // cycle ends on deasserting edge of chip-enable; type taken from prior sample
  logic end_cyc;
  assign end_cyc  = !ce_q && ce_ni;
  assign wr_evt_o = end_cyc && !we_q;
  assign rd_evt_o = end_cyc && we_q && !oe_q;
  assign bit_o    = d_q;

  // R3
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_evt_o && wr_evt_o));
endmodule

// File: rtl/sul_fsm.sv
module sul_fsm #(
  parameter int          WIDTH = 64,
  parameter logic [WIDTH-1:0] KEY = '0,
  localparam int         PTR_W = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_evt_i,
  input  logic             wr_evt_i,
  input  logic             bit_i,
  output logic             win_o,
  output logic [PTR_W-1:0] ptr_o
);
  import sul_pkg::*;

  localparam logic [PTR_W-1:0] LAST = PTR_W'(WIDTH - 1);

  sul_state_e state_q, state_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (rd_evt_i) begin
          state_d = ST_MATCH;
          ptr_d   = '0;
        end
      end
      ST_MATCH: begin
        if (rd_evt_i) begin
          ptr_d = '0;
        end else if (wr_evt_i) begin
          if (bit_i != KEY[ptr_q]) begin
            state_d = ST_IDLE;
            ptr_d   = '0;
          end else if (ptr_q == LAST) begin
            state_d = ST_WIN;
            ptr_d   = '0;
          end else begin
            ptr_d = ptr_q + 1'b1;
          end
        end
      end
      ST_WIN: begin
        if (rd_evt_i || wr_evt_i) begin
          if (ptr_q == LAST) begin
            state_d = ST_IDLE;
            ptr_d   = '0;
          end else begin
            ptr_d = ptr_q + 1'b1;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
        ptr_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
    end
  end

  assign win_o = (state_q == ST_WIN);
  assign ptr_o = ptr_q;

  // R4
  win_open_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(win_o) |-> $past(wr_evt_i));

  // R10
  win_close_on_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(win_o) |-> $past(rd_evt_i || wr_evt_i));

  // R5
  idle_ptr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (ptr_q == '0));

  // R4
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_evt_i || wr_evt_i) |=> $stable(ptr_q));
endmodule

// File: rtl/sul_store.sv
module sul_store #(
  parameter int WIDTH = 64,
  localparam int PTR_W = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PTR_W-1:0] idx_i,
  input  logic             bit_i,
  output logic             bit_o
);
  logic [WIDTH-1:0] mem_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[i] <= 1'b0;
      else if (we_i && (idx_i == PTR_W'(i)))        mem_q[i] <= bit_i;
    end
  end

  assign bit_o = mem_q[idx_i];

  // R8
  one_bit_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mem_q ^ $past(mem_q)) <= 1);

  // R8
  no_write_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q));
endmodule

// File: rtl/serial_unlock_ctrl.sv
module serial_unlock_ctrl #(
  parameter int               WIDTH = 64,
  parameter logic [WIDTH-1:0] KEY   = 64'hC5A3_3CA5_5AC3_A35C
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic we_ni,
  input  logic d_i,
  output logic ce_no,
  output logic q_o,
  output logic q_oe_o
);
  localparam int PTR_W = $clog2(WIDTH);

  logic rd_evt, wr_evt, bit_s, win;
  logic [PTR_W-1:0] ptr;
  logic rd_bit;

  sul_cycle_det u_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .we_ni    (we_ni),
    .d_i      (d_i),
    .rd_evt_o (rd_evt),
    .wr_evt_o (wr_evt),
    .bit_o    (bit_s)
  );

  sul_fsm #(.WIDTH(WIDTH), .KEY(KEY)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_evt_i (rd_evt),
    .wr_evt_i (wr_evt),
    .bit_i    (bit_s),
    .win_o    (win),
    .ptr_o    (ptr)
  );

  sul_store #(.WIDTH(WIDTH)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (win && wr_evt),
    .idx_i  (ptr),
    .bit_i  (bit_s),
    .bit_o  (rd_bit)
  );

  assign ce_no  = win ? 1'b1 : ce_ni;
  assign q_oe_o = win && !ce_ni && !oe_ni && we_ni;
  assign q_o    = q_oe_o ? rd_bit : 1'b0;

  // R7
  ce_held_in_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win && $past(win)) |-> (ce_no && $stable(ce_no)));

  // R9
  q_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_oe_o |-> !q_o);
endmodule

// File: tb/serial_unlock_ctrl_tb.sv
module serial_unlock_ctrl_tb;
  localparam logic [63:0] KEY = 64'hC5A3_3CA5_5AC3_A35C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, d = 1'b0;
  logic ce_o, q, q_oe;

  int checks = 0;
  int fails  = 0;

  // reference model
  int          m_state = 0;  // 0 idle, 1 matching, 2 window
  int          m_ptr   = 0;
  logic [63:0] m_reg   = '0;
  logic        rd_col;
  logic [63:0] got;

  always #10 clk = ~clk;

  serial_unlock_ctrl #(.WIDTH(64), .KEY(KEY)) u_dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .ce_ni  (ce_n),
    .oe_ni  (oe_n),
    .we_ni  (we_n),
    .d_i    (d),
    .ce_no  (ce_o),
    .q_o    (q),
    .q_oe_o (q_oe)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit rd, input bit wr, input logic b);
    case (m_state)
      0: if (rd) begin m_state = 1; m_ptr = 0; end
      1: begin
        if (rd) m_ptr = 0;
        else if (wr) begin
          if (b !== KEY[m_ptr]) begin m_state = 0; m_ptr = 0; end
          else if (m_ptr == 63) begin m_state = 2; m_ptr = 0; end
          else m_ptr++;
        end
      end
      default: begin
        if (wr) m_reg[m_ptr] = b;
        if (m_ptr == 63) begin m_state = 0; m_ptr = 0; end
        else m_ptr++;
      end
    endcase
  endtask

  // per-clock comparison against the model, R2 R7 R9
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      check(m_state == 2 ? "R7" : "R2", ce_o, (m_state == 2) ? 1'b1 : ce_n);
      check("R9", q_oe, (m_state == 2) && !ce_n && !oe_n && we_n);
      check("R9", q, ((m_state == 2) && !ce_n && !oe_n && we_n) ? m_reg[m_ptr] : 1'b0);
    end
  end

  task automatic bus(input bit rd, input bit wr, input logic b);
    @(negedge clk);
    ce_n = 1'b0; oe_n = rd ? 1'b0 : 1'b1; we_n = wr ? 1'b0 : 1'b1; d = b;
    repeat (2) @(negedge clk);
    if (rd && m_state == 2) rd_col = q;
    ce_n = 1'b1;
    @(posedge clk);
    model_step(rd, wr, b);
    @(negedge clk);
    oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic send_key(input int upto);
    for (int i = 0; i < upto; i++) bus(1'b0, 1'b1, KEY[i]);
  endtask

  task automatic unlock();
    bus(1'b1, 1'b0, 1'b0);
    send_key(64);
  endtask

  initial begin
    #100000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", ce_o, 1'b1);
    ce_n = 1'b0; #1 check("R1", ce_o, 1'b0); ce_n = 1'b1;
    check("R1", q_oe, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: plain memory traffic passes through
    bus(1'b0, 1'b1, 1'b1);
    bus(1'b1, 1'b0, 1'b0);
    bus(1'b0, 1'b1, 1'b0);

    // R6: key writes with no arming read (state idle after reset? R3 armed above; abort first)
    bus(1'b0, 1'b1, ~KEY[0]);
    check("R5", ce_o, ce_n);
    send_key(64);
    check("R6", logic'(m_state == 2), 1'b0);
    bus(1'b0, 1'b1, 1'b0);
    check("R6", ce_o, 1'b1);

    // R4 R8: full unlock, write a word
    unlock();
    check("R4", logic'(m_state == 2), 1'b1);
    for (int i = 0; i < 64; i++) bus(1'b0, 1'b1, logic'((64'hDEAD_BEEF_0123_4567 >> i) & 1));
    check("R10", logic'(m_state == 0), 1'b1);

    // R8 R9: read it back, LSB first
    unlock();
    for (int i = 0; i < 64; i++) begin
      bus(1'b1, 1'b0, 1'b0);
      got[i] = rd_col;
    end
    checks++;
    if (got !== 64'hDEAD_BEEF_0123_4567) begin
      fails++;
      $display("FAIL R8 actual=%h expected=%h", got, 64'hDEAD_BEEF_0123_4567);
    end

    // R10: window closed, memory cycles pass again
    bus(1'b1, 1'b0, 1'b0);
    check("R10", logic'(m_state == 1), 1'b1);

    // R5: mismatch mid-key then remaining key bits do not unlock
    bus(1'b1, 1'b0, 1'b0);
    send_key(10);
    bus(1'b0, 1'b1, ~KEY[10]);
    for (int i = 11; i < 64; i++) bus(1'b0, 1'b1, KEY[i]);
    check("R5", logic'(m_state == 2), 1'b0);

    // R3: restart by read partway through
    bus(1'b1, 1'b0, 1'b0);
    send_key(20);
    unlock();
    check("R3", logic'(m_state == 2), 1'b1);

    // R8 R9: interleaved window traffic
    for (int i = 0; i < 64; i++) begin
      if (i % 3 == 0) bus(1'b1, 1'b0, 1'b0);
      else bus(1'b0, 1'b1, logic'(i[1]));
    end
    check("R10", logic'(m_state == 0), 1'b1);

    // R8: verify interleaved result via read-back
    unlock();
    for (int i = 0; i < 64; i++) begin
      bus(1'b1, 1'b0, 1'b0);
      got[i] = rd_col;
    end
    checks++;
    if (got !== m_reg) begin
      fails++;
      $display("FAIL R8 actual=%h expected=%h", got, m_reg);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule